// File: doc/BRIEF.md
# Paged EEPROM Address Pointer and Page Write Buffer

This block is the storage-side core of a byte-addressed serial EEPROM model. A protocol front end, which decodes the bit-level serial traffic, hands it single-cycle byte events: a control byte was accepted (carrying a block-select bit and a read/write flag), the high or low word-address byte arrived, a data byte arrived, a data byte was sent to the host, and a stop condition was seen. The block keeps the internal address pointer and a page latch of `2**PAGE_W` bytes. It commits the latched bytes to a synthesizable storage array in a self-timed write cycle that lasts `WRITE_TICKS` clocks. During that cycle `busy` is high, and the front end uses it to withhold acknowledges.

The array holds `2**ADDR_W` bytes. A 64K x 8 part uses `ADDR_W = 16` and `PAGE_W = 6`. The most significant pointer bit comes from the block-select bit of the write control byte and splits the array into two halves. Reads return the byte at the pointer. The pointer steps within its page while write data arrives. It steps within its half while read bytes are sent. The write-protect input is looked at only when the stop arrives. At most one event is pulsed per cycle. `WRITE_TICKS` must exceed `2**PAGE_W`.

The controller has four states.
- `ST_IDLE`: no write command is open.
- `ST_LOAD`: a write command is gathering its address and data.
- `ST_PROG`: one page slot per cycle is copied into the array.
- `ST_SETTLE`: the controller waits out the rest of the write time.

Its transitions are:
- IDLE or LOAD to LOAD on a write control byte.
- LOAD to IDLE on a read control byte, or on a stop that starts no cycle.
- LOAD to PROG on a stop with at least one buffered byte and write protect low.
- PROG to SETTLE after the last slot.
- SETTLE to IDLE when the write time has elapsed.

Top module: `eep_page_core`

## Requirements
- R1: After reset `busy` is 0 and `cur_addr` is 0.
- R2: A write command loads the pointer when its low address byte arrives. The pointer's top bit is the command's block-select bit. The next `ADDR_W-9` bits are the low bits of the high address byte, and the bottom 8 bits are the low address byte. The remaining high-byte bits, including bit 7, are ignored.
- R3: Each data byte received in a write command is stored in the latch slot named by the low `PAGE_W` pointer bits, and only those bits then increment. Past the end of a page the pointer wraps to the page start, and a later byte for a slot replaces the earlier one.
- R4: The array is unchanged until the stop. The cycle then writes only the slots that received a byte in this command, and every other location of the page keeps its contents.
- R5: `wp_in` is sampled on the stop cycle. If it is 1, nothing is stored and `busy` stays 0.
- R6: A committing stop raises `busy` on the next cycle, and `busy` then stays high for exactly `WRITE_TICKS` cycles.
- R7: While `busy` is high, every event is ignored, and both the pointer and the array are left unchanged by it.
- R8: A stop in a write command that carries no data byte starts no cycle and keeps the loaded pointer.
- R9: Each `rd_done` advances the pointer by one within its half: the top bit holds, and the last address of a half wraps to the first.
- R10: After a byte write to n, and after sending byte n, the pointer is n+1 within the respective wrap rule.
- R11: `rd_data` always shows the array byte at `cur_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Control byte accepted |
| cmd_blk | input | 1 | Block-select bit of the control byte |
| cmd_rw | input | 1 | 1 = read command, 0 = write command |
| addr_hi_valid | input | 1 | High address byte on `byte_in` |
| addr_lo_valid | input | 1 | Low address byte on `byte_in` |
| wr_valid | input | 1 | Data byte on `byte_in` |
| byte_in | input | 8 | Received byte |
| rd_done | input | 1 | Data byte sent to host |
| stop_seen | input | 1 | Stop condition |
| wp_in | input | 1 | Write protect, 1 = protected |
| rd_data | output | 8 | Array byte at the pointer |
| cur_addr | output | ADDR_W | Address pointer |
| busy | output | 1 | Write cycle in progress |

## Verification
The hardest situation to reach is a write whose data runs past the end of its page while other slots of the same page stay untouched. The bench first fills the whole array through page writes, so a byte-exact model of the array exists. It then sends eleven bytes into an eight-byte page starting mid-page, and two bytes at a page offset, and reads the full pages back. Events pushed into the busy window and protected stops are checked by reading the pointer and the array afterwards.

// File: rtl/eep_pkg.sv
package eep_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG,
        ST_SETTLE
    } eep_state_t;
endpackage

// File: rtl/eep_ptr.sv
// Address pointer: loads a full address, steps inside a page or inside a half.
module eep_ptr #(
    parameter int ADDR_W = 12,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              page_step,
    input  logic              half_step,
    output logic [ADDR_W-1:0] ptr
);
    localparam int LOW_W = ADDR_W - 1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load_en) begin
            ptr <= load_addr;
        end else if (page_step) begin
            ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
        end else if (half_step) begin
            ptr <= {ptr[ADDR_W-1], ptr[LOW_W-1:0] + 1'b1};
        end
    end
endmodule

// File: rtl/eep_latch.sv
// Page latch: one data byte and one written-mark per slot.
module eep_latch #(
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_slot,
    input  logic [7:0]        wr_byte,
    input  logic [PAGE_W-1:0] rd_slot,
    output logic [7:0]        rd_byte,
    output logic              rd_mark,
    output logic              any_mark
);
    localparam int PAGE_SZ = 1 << PAGE_W;

    logic       mark_q [PAGE_SZ];
    logic [7:0] data_q [PAGE_SZ];

    for (genvar s = 0; s < PAGE_SZ; s++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mark_q[s] <= 1'b0;
                data_q[s] <= '0;
            end else if (clr) begin
                mark_q[s] <= 1'b0;
            end else if (wr_en && (wr_slot == PAGE_W'(s))) begin
                mark_q[s] <= 1'b1;
                data_q[s] <= wr_byte;
            end
        end
    end

    always_comb begin
        any_mark = 1'b0;
        for (int i = 0; i < PAGE_SZ; i++) begin
            any_mark = any_mark | mark_q[i];
        end
    end

    assign rd_byte = data_q[rd_slot];
    assign rd_mark = mark_q[rd_slot];
endmodule

// File: rtl/eep_store.sv
// Storage array: one write port, one asynchronous read port, no reset.
module eep_store #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eep_page_core.sv
module eep_page_core
    import eep_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 6,
    parameter int WRITE_TICKS = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_blk,
    input  logic              cmd_rw,
    input  logic              addr_hi_valid,
    input  logic              addr_lo_valid,
    input  logic              wr_valid,
    input  logic [7:0]        byte_in,
    input  logic              rd_done,
    input  logic              stop_seen,
    input  logic              wp_in,
    output logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              busy
);
    localparam int LOW_W   = ADDR_W - 1;
    localparam int HI_KEEP = LOW_W - 8;
    localparam int PAGE_SZ = 1 << PAGE_W;
    localparam int TMR_W   = $clog2(WRITE_TICKS + 1);
    localparam int BASE_W  = ADDR_W - PAGE_W;

    eep_state_t state_q, state_d;

    logic               blk_q;
    logic [HI_KEEP-1:0] hi_q;
    logic               hi_seen_q;
    logic               addr_ok_q;
    logic [BASE_W-1:0]  base_q;
    logic [TMR_W-1:0]   tmr_q;

    logic cap_cmd, cap_hi, addr_load, data_take, half_step, start_prog, prog_we;
    logic [PAGE_W-1:0] slot_idx;
    logic [7:0]        slot_byte;
    logic              slot_mark;
    logic              any_mark;
    logic [ADDR_W-1:0] load_addr;
    logic [ADDR_W-1:0] ptr;

    assign load_addr = {blk_q, hi_q, byte_in};
    assign slot_idx  = tmr_q[PAGE_W-1:0];
    assign busy      = (state_q == ST_PROG) || (state_q == ST_SETTLE);
    assign cur_addr  = ptr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and control strobes
    always_comb begin
        state_d    = state_q;
        cap_cmd    = 1'b0;
        cap_hi     = 1'b0;
        addr_load  = 1'b0;
        data_take  = 1'b0;
        half_step  = 1'b0;
        start_prog = 1'b0;
        prog_we    = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_LOAD: begin
                if (cmd_valid) begin
                    if (!cmd_rw) begin
                        cap_cmd = 1'b1;
                        state_d = ST_LOAD;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (state_q == ST_LOAD && addr_hi_valid && !hi_seen_q) begin
                    cap_hi = 1'b1;
                end else if (state_q == ST_LOAD && addr_lo_valid && hi_seen_q && !addr_ok_q) begin
                    addr_load = 1'b1;
                end else if (state_q == ST_LOAD && wr_valid && addr_ok_q) begin
                    data_take = 1'b1;
                end else if (rd_done) begin
                    half_step = 1'b1;
                end else if (state_q == ST_LOAD && stop_seen) begin
                    if (addr_ok_q && any_mark && !wp_in) begin
                        start_prog = 1'b1;
                        state_d    = ST_PROG;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            ST_PROG: begin
                prog_we = slot_mark;
                if (tmr_q == TMR_W'(PAGE_SZ - 1)) begin
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (tmr_q >= TMR_W'(WRITE_TICKS - 1)) begin
                    state_d = ST_IDLE;
                end
            end
        endcase
    end

    // Command context and write-cycle timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q     <= 1'b0;
            hi_q      <= '0;
            hi_seen_q <= 1'b0;
            addr_ok_q <= 1'b0;
            base_q    <= '0;
            tmr_q     <= '0;
        end else begin
            if (cap_cmd) begin
                blk_q     <= cmd_blk;
                hi_seen_q <= 1'b0;
                addr_ok_q <= 1'b0;
            end
            if (cap_hi) begin
                hi_q      <= byte_in[HI_KEEP-1:0];
                hi_seen_q <= 1'b1;
            end
            if (addr_load) begin
                addr_ok_q <= 1'b1;
            end
            if (start_prog) begin
                base_q <= ptr[ADDR_W-1:PAGE_W];
                tmr_q  <= '0;
            end else if (busy) begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    eep_ptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (addr_load),
        .load_addr(load_addr),
        .page_step(data_take),
        .half_step(half_step),
        .ptr      (ptr)
    );

    eep_latch #(.PAGE_W(PAGE_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cap_cmd),
        .wr_en   (data_take),
        .wr_slot (ptr[PAGE_W-1:0]),
        .wr_byte (byte_in),
        .rd_slot (slot_idx),
        .rd_byte (slot_byte),
        .rd_mark (slot_mark),
        .any_mark(any_mark)
    );

    eep_store #(.ADDR_W(ADDR_W)) u_store (
        .clk  (clk),
        .we   (prog_we),
        .waddr({base_q, slot_idx}),
        .wdata(slot_byte),
        .raddr(ptr),
        .rdata(rd_data)
    );
endmodule

// File: rtl/eep_page_core_chk.sv
module eep_page_core_chk #(
    parameter int ADDR_W      = 12,
    parameter int PAGE_W      = 6,
    parameter int WRITE_TICKS = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              addr_hi_valid,
    input logic              addr_lo_valid,
    input logic              wr_valid,
    input logic              rd_done,
    input logic              stop_seen,
    input logic              wp_in,
    input logic              busy,
    input logic [ADDR_W-1:0] cur_addr
);
    localparam int LOW_W = ADDR_W - 1;
    localparam int RUN_W = $clog2(WRITE_TICKS + 2) + 1;

    logic [RUN_W-1:0] run_q;
    logic             others;

    assign others = cmd_valid | addr_hi_valid | addr_lo_valid | stop_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= busy ? run_q + 1'b1 : '0;
        end
    end

    AST_BUSY_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run_q == RUN_W'(WRITE_TICKS)); // R6

    AST_BUSY_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_seen)); // R4

    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_seen && wp_in && !busy) |=> !busy); // R5

    AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (others || wr_valid || rd_done)) |=> $stable(cur_addr)); // R7

    AST_PAGE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !others && !rd_done) |=> $stable(cur_addr[ADDR_W-1:PAGE_W])); // R3

    AST_HALF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !busy && !others && !wr_valid) |=>
        (cur_addr[ADDR_W-1] == $past(cur_addr[ADDR_W-1])) &&
        (cur_addr[LOW_W-1:0] == LOW_W'($past(cur_addr[LOW_W-1:0]) + 1'b1))); // R9
endmodule

bind eep_page_core eep_page_core_chk #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WRITE_TICKS(WRITE_TICKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .addr_hi_valid(addr_hi_valid),
    .addr_lo_valid(addr_lo_valid),
    .wr_valid     (wr_valid),
    .rd_done      (rd_done),
    .stop_seen    (stop_seen),
    .wp_in        (wp_in),
    .busy         (busy),
    .cur_addr     (cur_addr)
);

// File: tb/sim_eep_page_core.sv
module sim_eep_page_core;
    localparam int AW   = 10;
    localparam int PW   = 3;
    localparam int WT   = 20;
    localparam int SZ   = 1 << AW;
    localparam int HALF = SZ / 2;
    localparam int PG   = 1 << PW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 0, cmd_blk = 0, cmd_rw = 0, addr_hi_valid = 0, addr_lo_valid = 0;
    logic wr_valid = 0, rd_done = 0, stop_seen = 0, wp_in = 0;
    logic [7:0] byte_in = '0;
    logic [7:0] rd_data;
    logic [AW-1:0] cur_addr;
    logic busy;

    int n_chk = 0;
    int n_err = 0;
    logic [7:0] mem_m [SZ];
    int ptr_m = 0;

    always #2.5 clk = ~clk;

    eep_page_core #(.ADDR_W(AW), .PAGE_W(PW), .WRITE_TICKS(WT)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_blk(cmd_blk), .cmd_rw(cmd_rw),
        .addr_hi_valid(addr_hi_valid), .addr_lo_valid(addr_lo_valid), .wr_valid(wr_valid),
        .byte_in(byte_in), .rd_done(rd_done), .stop_seen(stop_seen), .wp_in(wp_in),
        .rd_data(rd_data), .cur_addr(cur_addr), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ev_cmd(input logic b, input logic rw);
        cmd_valid = 1; cmd_blk = b; cmd_rw = rw;
        @(negedge clk); cmd_valid = 0;
    endtask
    task automatic ev_hi(input logic [7:0] d);
        addr_hi_valid = 1; byte_in = d; @(negedge clk); addr_hi_valid = 0;
    endtask
    task automatic ev_lo(input logic [7:0] d);
        addr_lo_valid = 1; byte_in = d; @(negedge clk); addr_lo_valid = 0;
    endtask
    task automatic ev_wr(input logic [7:0] d);
        wr_valid = 1; byte_in = d; @(negedge clk); wr_valid = 0;
    endtask
    task automatic ev_rd();
        rd_done = 1; @(negedge clk); rd_done = 0;
        ptr_m = (ptr_m & HALF) | ((ptr_m + 1) & (HALF - 1));
    endtask
    task automatic ev_stop(input logic w);
        stop_seen = 1; wp_in = w; @(negedge clk); stop_seen = 0; wp_in = 0;
    endtask

    // High byte carries junk in every bit the array does not use (bit 7 set)
    task automatic set_addr(input int a);
        ev_cmd(a[AW-1], 1'b0);
        ev_hi({7'b1011010, a[8]});
        ev_lo(a[7:0]);
        ptr_m = a;
    endtask

    task automatic check_rd(input string tag);
        chk(rd_data == mem_m[ptr_m], tag, int'(rd_data), int'(mem_m[ptr_m]));
    endtask

    task automatic wait_idle(input int already, input bit check_len);
        int n = already;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        if (check_len) chk(n == WT, "R6 busy length", n, WT);
    endtask

    task automatic do_write(input int a, input int n, input logic w, input int seed, input bit pre);
        logic [7:0] pd [PG];
        bit pm [PG];
        int base;
        for (int s = 0; s < PG; s++) pm[s] = 0;
        set_addr(a);
        for (int i = 0; i < n; i++) begin
            logic [7:0] d = 8'(i * 29 + seed);
            pd[ptr_m & (PG - 1)] = d;
            pm[ptr_m & (PG - 1)] = 1;
            ev_wr(d);
            ptr_m = (ptr_m & ~(PG - 1)) | ((ptr_m + 1) & (PG - 1));
        end
        if (pre) check_rd("R4 array untouched before stop");
        ev_stop(w);
        base = ptr_m & ~(PG - 1);
        if (!w && n > 0) begin
            chk(busy == 1'b1, "R6 busy after stop", int'(busy), 1);
            for (int s = 0; s < PG; s++) if (pm[s]) mem_m[base + s] = pd[s];
        end else begin
            chk(busy == 1'b0, (w ? "R5 protected stop" : "R8 empty stop"), int'(busy), 0);
        end
    endtask

    task automatic read_page(input int base, input string tag);
        set_addr(base);
        ev_cmd(base[AW-1], 1'b1);
        for (int i = 0; i < PG; i++) begin
            check_rd(tag);
            ev_rd();
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
        chk(cur_addr == '0, "R1 pointer at reset", int'(cur_addr), 0);

        // Fill the whole array page by page
        for (int p = 0; p < SZ / PG; p++) begin
            do_write(p * PG, PG, 1'b0, p * 13, 1'b0);
            wait_idle(0, 1'b1);
        end

        // Sequential sweep of each half including the wrap (R9, R11, R2)
        for (int h = 0; h < 2; h++) begin
            set_addr(h * HALF);
            chk(int'(cur_addr) == h * HALF, "R2 loaded pointer", int'(cur_addr), h * HALF);
            ev_cmd(h[0], 1'b1);
            for (int i = 0; i <= HALF; i++) begin
                check_rd("R11 R9 sequential read");
                ev_rd();
            end
            chk(int'(cur_addr) == h * HALF + 1, "R9 half wrap", int'(cur_addr), h * HALF + 1);
        end

        // Page overrun from mid-page: 11 bytes into 8 slots (R3)
        do_write(12'h045, 11, 1'b0, 77, 1'b0);
        wait_idle(0, 1'b1);
        chk(int'(cur_addr) == ptr_m, "R3 pointer wrapped in page", int'(cur_addr), ptr_m);
        check_rd("R10 R3 current read after wrap");
        read_page(12'h040, "R3 page contents");

        // Partial write keeps neighbours (R4)
        do_write(12'h1A3, 2, 1'b0, 5, 1'b1);
        wait_idle(0, 1'b1);
        read_page(12'h1A0, "R4 partial page");

        // Protected write (R5)
        do_write(12'h2B6, 4, 1'b1, 200, 1'b0);
        @(negedge clk);
        chk(busy == 1'b0, "R5 no cycle under protect", int'(busy), 0);
        read_page(12'h2B0, "R5 contents kept");

        // Empty write (R8, R2 upper half)
        do_write(12'h3C5, 0, 1'b0, 0, 1'b0);
        chk(int'(cur_addr) == 12'h3C5, "R8 pointer kept", int'(cur_addr), 12'h3C5);
        check_rd("R8 R11 read at loaded address");

        // Byte write then current-address read (R10)
        do_write(12'h0F2, 1, 1'b0, 9, 1'b0);
        ev_cmd(1'b1, 1'b0); ev_hi(8'hFF); ev_lo(8'h00); ev_wr(8'h11); ev_rd(); ev_stop(1'b0);
        ptr_m = (ptr_m & HALF) | ((ptr_m - 1) & (HALF - 1)); // rd_done ignored while busy
        wait_idle(6, 1'b1);
        chk(int'(cur_addr) == 12'h0F3, "R10 R7 pointer after byte write", int'(cur_addr), 12'h0F3);
        ptr_m = 12'h0F3;
        check_rd("R10 current address read");
        ev_cmd(1'b0, 1'b1);
        ev_rd();
        chk(int'(cur_addr) == 12'h0F4, "R10 after read", int'(cur_addr), 12'h0F4);
        read_page(12'h300, "R7 busy events stored nothing");
        read_page(12'h0F0, "R10 written page");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule